// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Receive Queue

This block is a serial port on a processor's memory-mapped I/O bus. The processor sees three word-aligned locations. Storing a word at the transmit location hands its low byte to a shifter, which sends the byte as an asynchronous frame. Loading from the receive location hands back the oldest byte held in a receive queue and removes it. Loading from the status location shows whether the transmitter is still sending and whether received data is waiting.

The frame format is fixed at one start bit, eight data bits sent least significant bit first, no parity and one stop bit. The line rests high between frames. Each bit lasts a whole number of system clocks, taken from the clock rate divided by the baud rate and rounded to the nearest integer. That is 434 clocks for 115200 baud from 50 MHz. Reset is synchronous and active-high.

On the receive side, the input passes through a two-stage synchronizer. A falling edge is taken as a start bit only if the line is still low half a bit later. Each data bit is then sampled at its centre. A frame whose stop bit reads low is thrown away. The receive queue is 16 entries deep, and a byte that arrives while the queue is full is lost. Firmware must poll the busy bit before it stores a new byte.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `uart_txd` is high, the status word is zero, and a load from the receive offset returns zero.
- R2: A write to offset 0x0 while the transmitter is idle sends `bus_wdata[7:0]` on `uart_txd`. The frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit is held for BIT_CLKS = round(CLK_HZ/BAUD) clocks, and the start bit begins in the cycle after the write edge. While the transmitter is idle the line is high.
- R3: Status bit 0 (transmit busy) is 1 from the write edge for exactly 10*BIT_CLKS clocks.
- R4: A write to offset 0x0 while the transmitter is busy is ignored. The frame in progress and the busy window are unchanged.
- R5: A low pulse on `uart_rxd` shorter than half a bit is not taken as a start bit, and no byte is queued.
- R6: A received frame is sampled at bit centres, LSB first. Its byte enters the queue only if the stop bit reads high. A frame with a low stop bit is discarded.
- R7: A read at offset 0x4 returns the oldest queued byte in `bus_rdata[7:0]`, with bits 31..8 zero, in the cycle after the read strobe. It removes that byte, so bytes come out in arrival order.
- R8: The queue holds 16 bytes. A byte arriving while it holds 16 is dropped, and the stored bytes are kept.
- R9: A read at offset 0x4 while the queue is empty returns zero and leaves the queue unchanged.
- R10: Status read at offset 0x8 has bit 1 = queue not empty, bit 0 = transmit busy, bits 31..2 zero.
- R11: Writes to offsets 0x4 and 0x8 have no effect. A read of any offset other than 0x4 and 0x8 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, low byte used by the transmitter |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| uart_rxd | input | 1 | Asynchronous serial input |
| uart_txd | output | 1 | Serial output, high when idle |

## Verification
A miscounted bit timer in the transmitter shows up on `uart_txd`. A bit edge lands away from the sampled centres within the first bit or two, and the busy bit falls at the wrong cycle after ten bit periods. A wrong receive state or queue pointer shows up at the next bus read of offset 0x4 or 0x8. It appears as a byte with shifted bits, bytes out of order, a phantom byte after a glitch or a bad stop bit, or a lost or overwritten byte after the sixteenth arrival. Random byte streams in both directions are compared against bench-built frames and a bench-side queue. Directed cases cover glitches, framing errors, overflow, empty reads and writes to read-only offsets.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

  localparam int unsigned OFS_TXDATA = 32'h0;
  localparam int unsigned OFS_RXDATA = 32'h4;
  localparam int unsigned OFS_STATUS = 32'h8;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Nearest integer clocks per serial bit.
  function automatic int unsigned bit_clocks(int unsigned clk_hz, int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

  // Full serial frame, bit 0 goes out first.
  function automatic logic [FRAME_BITS-1:0] frame_of(logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int unsigned BIT_CLKS = 434
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output logic       busy,
  output logic       txd
);
  import uart_mmio_pkg::*;

  localparam int unsigned CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      bit_idx;
  logic [CNT_W-1:0]      tick_cnt;
  logic                  bit_end;

  assign bit_end = (tick_cnt == CNT_W'(BIT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shreg    <= '1;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (!busy) begin
      if (load) begin
        shreg    <= frame_of(data);
        busy     <= 1'b1;
        bit_idx  <= '0;
        tick_cnt <= '0;
      end
    end else if (bit_end) begin
      tick_cnt <= '0;
      shreg    <= {1'b1, shreg[FRAME_BITS-1:1]};
      if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int unsigned BIT_CLKS = 434
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd_async,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  import uart_mmio_pkg::*;

  localparam int unsigned CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned HALF  = BIT_CLKS / 2;

  logic [1:0]       sync_q;
  logic             line;
  rx_state_e        state;
  logic [CNT_W-1:0] tick_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             mid_start;
  logic             bit_end;

  assign line      = sync_q[1];
  assign mid_start = (tick_cnt == CNT_W'(HALF - 1));
  assign bit_end   = (tick_cnt == CNT_W'(BIT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rxd_async};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      tick_cnt   <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          tick_cnt <= '0;
          if (!line) state <= RX_START;
        end
        RX_START: begin
          if (mid_start) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            state    <= line ? RX_IDLE : RX_DATA;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            tick_cnt <= '0;
            shreg    <= {line, shreg[7:1]};
            bit_idx  <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) state <= RX_STOP;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            tick_cnt   <= '0;
            byte_valid <= line;
            state      <= RX_IDLE;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign byte_data = shreg;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [DW-1:0]                  push_data,
  input  logic                           pop,
  output logic [DW-1:0]                  head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          full;
  logic          empty;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned BAUD       = 115_200,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              uart_rxd,
  output logic              uart_txd
);
  import uart_mmio_pkg::*;

  localparam int unsigned BIT_CLKS = bit_clocks(CLK_HZ, BAUD);
  localparam int unsigned FCW      = $clog2(FIFO_DEPTH + 1);

  // Named events for the bound checker.
  logic           sel_tx;
  logic           sel_rx;
  logic           sel_st;
  logic           tx_load;
  logic           tx_busy;
  logic           rx_valid;
  logic [7:0]     rx_byte;
  logic           rx_pop;
  logic [7:0]     fifo_head;
  logic [FCW-1:0] fifo_count;
  logic           fifo_nonempty;
  wire            unused_wdata_hi = ^bus_wdata[31:8];

  assign sel_tx        = (bus_addr == ADDR_W'(OFS_TXDATA));
  assign sel_rx        = (bus_addr == ADDR_W'(OFS_RXDATA));
  assign sel_st        = (bus_addr == ADDR_W'(OFS_STATUS));
  assign tx_load       = bus_wr && sel_tx && !tx_busy;
  assign rx_pop        = bus_rd && sel_rx;
  assign fifo_nonempty = (fifo_count != '0);

  uart_tx_shifter #(.BIT_CLKS(BIT_CLKS)) i_tx (
    .clk  (clk),
    .rst  (rst),
    .load (tx_load),
    .data (bus_wdata[7:0]),
    .busy (tx_busy),
    .txd  (uart_txd)
  );

  uart_rx_sampler #(.BIT_CLKS(BIT_CLKS)) i_rx (
    .clk        (clk),
    .rst        (rst),
    .rxd_async  (uart_rxd),
    .byte_valid (rx_valid),
    .byte_data  (rx_byte)
  );

  uart_rx_queue #(.DW(8), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (rx_pop),
    .head      (fifo_head),
    .count     (fifo_count)
  );

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else if (sel_rx) begin
      bus_rdata <= {24'd0, fifo_head};
    end else if (sel_st) begin
      bus_rdata <= {30'd0, fifo_nonempty, tx_busy};
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CPB    = 434,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned FCW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              uart_txd,
  input logic              tx_busy,
  input logic [FCW-1:0]    fifo_count,
  input logic              rx_valid
);
  // Independent busy window model, counted rather than delayed.
  int unsigned left;
  always_ff @(posedge clk) begin
    if (rst) left <= 0;
    else if (bus_wr && bus_addr == ADDR_W'(0) && left == 0) left <= 10 * CPB;
    else if (left != 0) left <= left - 1;
  end

  logic rd_rx, rd_st, rd_other;
  assign rd_rx    = bus_rd && bus_addr == ADDR_W'(4);
  assign rd_st    = bus_rd && bus_addr == ADDR_W'(8);
  assign rd_other = bus_rd && !rd_rx && !rd_st;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> uart_txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !uart_txd);
  // R3 and R4: busy lasts ten bit times, never restarted by a write
  assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
    tx_busy == (left != 0));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= FCW'(DEPTH));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fifo_count == FCW'(DEPTH) && !rd_rx) |=> fifo_count == FCW'(DEPTH));
  assert_push_grow_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fifo_count < FCW'(DEPTH) && !rd_rx) |=> fifo_count == $past(fifo_count) + 1'b1);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && fifo_count == '0 && !rx_valid) |=> (bus_rdata == '0 && fifo_count == '0));
  assert_rx_upper_R7: assert property (@(posedge clk) disable iff (rst)
    rd_rx |=> bus_rdata[31:8] == '0);
  assert_status_bits_R10: assert property (@(posedge clk) disable iff (rst)
    rd_st |=> (bus_rdata[31:2] == '0 && bus_rdata[1] == $past(fifo_count != '0)));
  assert_other_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_other |=> bus_rdata == '0);

endmodule

bind uart_mmio uart_mmio_chk #(
  .ADDR_W (ADDR_W),
  .CPB    (BIT_CLKS),
  .DEPTH  (FIFO_DEPTH),
  .FCW    (FCW)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .uart_txd   (uart_txd),
  .tx_busy    (tx_busy),
  .fifo_count (fifo_count),
  .rx_valid   (rx_valid)
);

// File: tb/test_uart_mmio.sv
module test_uart_mmio;
  localparam int unsigned CLK_HZ = 1600;
  localparam int unsigned BAUD   = 100;
  localparam int CPB   = 16;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        uart_rxd = 1'b1;
  logic        uart_txd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] q [DEPTH];
  int q_n = 0;

  always #5 clk = ~clk;

  uart_mmio #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH), .ADDR_W(4)) i_uart_mmio (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .uart_rxd(uart_rxd), .uart_txd(uart_txd)
  );

  function automatic logic exp_line(logic [7:0] b, int j);
    if (j == 0) return 1'b0;
    if (j == 9) return 1'b1;
    return b[j-1];
  endfunction

  function automatic logic [31:0] exp_status(bit busy, int n);
    return {30'd0, (n != 0), busy};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Send one byte and check the line at each bit centre and the busy window.
  task automatic tx_frame(input logic [7:0] b, input bit interfere);
    logic [31:0] d;
    int bad_line = 0;
    bus_write(4'h0, {$urandom, b} >> 0 & 32'hFFFF_FF00 | {24'd0, b});
    repeat (CPB / 2) @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      if (uart_txd !== exp_line(b, j)) bad_line++;
      if (j < 9) begin
        if (interfere && j == 4) begin
          bus_write(4'h0, {24'd0, ~b});
          repeat (CPB - 1) @(negedge clk);
        end else begin
          repeat (CPB) @(negedge clk);
        end
      end
    end
    check(bad_line, 0, interfere ? "R4 frame bits with write during busy" : "R2 frame bits");
    repeat (CPB / 2 - 1) @(negedge clk);
    bus_read(4'h8, d);
    check(d[0], 1'b1, "R3 busy in last cycle");
    bus_read(4'h8, d);
    check(d[0], 1'b0, "R3 busy cleared after ten bits");
    check(uart_txd, 1'b1, "R2 idle line high");
  endtask

  task automatic rx_frame(input logic [7:0] b, input bit stop_ok);
    for (int j = 0; j < 10; j++) begin
      uart_rxd = (j == 9) ? stop_ok : exp_line(b, j);
      repeat (CPB) @(negedge clk);
    end
    uart_rxd = 1'b1;
    if (!stop_ok) repeat (2 * CPB) @(negedge clk);
    if (stop_ok && q_n < DEPTH) begin
      q[q_n] = b;
      q_n++;
    end
  endtask

  task automatic drain(input string req);
    logic [31:0] d;
    int n = q_n;
    for (int i = 0; i < n; i++) begin
      bus_read(4'h4, d);
      check(d, {24'd0, q[i]}, req);
    end
    q_n = 0;
    bus_read(4'h8, d);
    check(d, exp_status(1'b0, 0), "R10 status empty after drain");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(uart_txd, 1'b1, "R1 txd after reset");
    bus_read(4'h8, d);
    check(d, 32'd0, "R1 status after reset");
    bus_read(4'h4, d);
    check(d, 32'd0, "R1 R9 empty rx read after reset");

    // R11 writes to read-only offsets
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'h4, 32'h0000_00A5);
    repeat (3) @(negedge clk);
    check(uart_txd, 1'b1, "R11 no frame from read-only write");
    bus_read(4'h8, d);
    check(d, 32'd0, "R11 status unchanged by writes");
    bus_read(4'hC, d);
    check(d, 32'd0, "R11 unused offset reads zero");
    bus_read(4'h0, d);
    check(d, 32'd0, "R11 tx offset reads zero");

    // R2 R3 directed and R4 interference
    tx_frame(8'h00, 1'b0);
    tx_frame(8'hFF, 1'b0);
    tx_frame(8'h5A, 1'b1);
    for (int i = 0; i < 5; i++) tx_frame(8'($urandom), 1'b0);

    // R5 glitch shorter than half a bit
    uart_rxd = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    bus_read(4'h8, d);
    check(d, exp_status(1'b0, 0), "R5 glitch leaves queue empty");

    // R6 framing error discards, good frame after it kept
    rx_frame(8'hC3, 1'b0);
    bus_read(4'h8, d);
    check(d, exp_status(1'b0, 0), "R6 bad stop discarded");
    rx_frame(8'h81, 1'b1);
    bus_read(4'h8, d);
    check(d, exp_status(1'b0, 1), "R10 status shows data");
    bus_write(4'h4, 32'h0);
    bus_read(4'h8, d);
    check(d, exp_status(1'b0, 1), "R11 write to rx offset keeps data");
    drain("R6 R7 received byte");

    // R6 R7 random streams with random gaps
    for (int r = 0; r < 4; r++) begin
      int n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) begin
        rx_frame(8'($urandom), 1'b1);
        repeat ($urandom % CPB) @(negedge clk);
      end
      drain("R7 order of random bytes");
    end

    // R8 overflow: seventeenth byte dropped
    for (int i = 0; i < DEPTH + 1; i++) rx_frame(8'(8'h30 + i), 1'b1);
    check(q_n, DEPTH, "R8 bench queue full");
    drain("R8 stored bytes kept after overflow");
    bus_read(4'h4, d);
    check(d, 32'd0, "R8 R9 dropped byte absent, empty read zero");
    bus_read(4'h4, d);
    check(d, 32'd0, "R9 second empty read");
    rx_frame(8'h7E, 1'b1);
    drain("R9 pointers intact after empty reads");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule